// File: doc/BRIEF.md
# Memory-Mapped NAND Cycle Bridge

This block lets a simple processor bus talk to an 8-bit asynchronous NAND flash port through plain loads and stores. Bus addresses with the top bit clear fall in a byte-addressed flash window. A store to that window becomes one or more NAND write cycles. Two address bits decide whether each cycle is a command latch, an address latch or a data transfer. A load from the window becomes NAND read cycles. A 16-bit access is split into two byte-wide flash cycles and a 32-bit access into four, always least significant byte first.

Bus addresses with the top bit set reach a small register space. It holds one NAND-mode enable bit for each core chip-select, a status word that reports the shared ready/busy line, and a fixed revision word. A further address bit steers a cycle onto a secondary chip-enable, which serves as the second die of a multichip package. The bus sees one request pulse for each access and a one-cycle acknowledge at its end. While the bridge is busy it takes no new request.

Top module: `nand_cycle_bridge`

## Requirements
- R1: A window store whose address has bit 4 set produces cycles with the command-latch output high and the address-latch output low. This holds even when bit 3 is also set.
- R2: A window store with bit 4 clear and bit 3 set produces cycles with the address-latch output high and the command-latch output low.
- R3: A window store with bits 4 and 3 both clear, and every window load, produces cycles with both latch outputs low.
- R4: The size field (0 byte, 1 halfword, 2 word) sets the number of flash cycles per access to 1, 2 or 4. Lanes are sent least significant byte first, and address bits 1:0 have no effect.
- R5: Each flash cycle has SETUP_CYC clocks of setup, a write or read strobe held low for exactly STRB_CYC clocks (default 2), and HOLD_CYC clocks of hold. Write data stays stable while the strobe is low.
- R6: A window load samples the flash data bus in the last strobe clock of each cycle. The acknowledge returns the bytes packed least significant lane first, with unused upper bytes zero.
- R7: Register offset 0 (address bits 3:2 = 0) holds one NAND-mode enable bit per chip-select, at the bit position equal to the chip-select index. A window access to a chip-select whose bit is clear drives no strobe and no chip-enable. It is still acknowledged, and a load returns 0.
- R8: When window address bit SEC_BIT (default 12) is set, the cycles assert the secondary chip-enable instead of the primary chip-enable of the selected chip-select. At most one chip-enable is low at any time.
- R9: Register offset 1 returns the ready/busy input in bit 0 (1 = ready) after a two-flop synchroniser. All other bits read 0.
- R10: Register offset 2 is read-only and returns REV_MAJOR in bits 15:8 and REV_MINOR in bits 7:0.
- R11: Busy rises on the clock edge that accepts a request and stays high through the acknowledge. A request pulse that arrives while busy is dropped and produces no flash cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | AW | Byte address; top bit selects the register space |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_cs | input | CSW | Core chip-select index for window accesses |
| bus_wdata | input | 32 | Store data |
| bus_busy | output | 1 | Access in progress, requests ignored |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Load data, valid with bus_ack |
| nand_ce_n | output | NCS | Primary chip-enables, active low |
| nand_ce2_n | output | 1 | Secondary chip-enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_in | input | 8 | Flash data in |
| nand_wait | input | 1 | Wired-AND ready/busy, 1 = ready |

## Verification
Two functions can fall in the same cycle: a new request arrives while the byte sequencer is still working through the lanes of a word access. The bench sends a command-store pulse in the middle of a four-lane store. A scoreboard then checks that exactly the four expected lanes appear on the flash pins and that nothing follows them. A second overlap is the address-bit decode against the per-lane sequencing. An address store with bits 1:0 set must keep the address-latch state on every lane. Each lane is compared on its strobe edge against an item queued by the driver.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // index of the last byte lane for a given access size
  function automatic logic [1:0] last_lane(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: last_lane = 2'd0;
      SZ_HALF: last_lane = 2'd1;
      default: last_lane = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs #(
  parameter int         NCS       = 4,
  parameter logic [7:0] REV_MAJOR = 8'd3,
  parameter logic [7:0] REV_MINOR = 8'd1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic [NCS-1:0] wr_val,
  input  logic [1:0]     rd_sel,
  input  logic           wait_in,
  output logic [NCS-1:0] mode_en,
  output logic [31:0]    rd_val
);

  logic [NCS-1:0] ctrl_q, ctrl_d;
  logic           rdy_meta_q, rdy_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rdy_meta_q <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      rdy_meta_q <= wait_in;
      rdy_q      <= rdy_meta_q;
    end
  end

  assign mode_en = ctrl_q;

  always_comb begin
    rd_val = '0;
    case (rd_sel)
      2'd0:    rd_val[NCS-1:0] = ctrl_q;
      2'd1:    rd_val[0]       = rdy_q;
      2'd2:    rd_val[15:0]    = {REV_MAJOR, REV_MINOR};
      default: rd_val = '0;
    endcase
  end

endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
  import nand_bridge_pkg::*;
#(
  parameter int CSW       = 2,
  parameter int SETUP_CYC = 1,
  parameter int STRB_CYC  = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_flash,
  input  logic           start_we,
  input  logic           start_cle,
  input  logic           start_ale,
  input  logic           start_sec,
  input  logic [CSW-1:0] start_cs,
  input  logic [1:0]     start_last,
  input  logic [31:0]    start_wdata,
  input  logic [31:0]    start_rval,
  input  logic [7:0]     dq_in,
  output logic           busy,
  output logic           ack,
  output logic [31:0]    rdata,
  output logic           cyc_on,
  output logic           cur_sec,
  output logic [CSW-1:0] cur_cs,
  output logic           cle,
  output logic           ale,
  output logic           we_n,
  output logic           re_n,
  output logic [7:0]     dq_out,
  output logic           dq_oe
);

  localparam int TMAX = (SETUP_CYC > STRB_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((STRB_CYC > HOLD_CYC) ? STRB_CYC : HOLD_CYC);
  localparam int CW = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam logic [CW-1:0] SU_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] ST_LD = CW'(STRB_CYC - 1);
  localparam logic [CW-1:0] HO_LD = CW'(HOLD_CYC - 1);

  seq_state_t     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [1:0]     lane_q, lane_d, last_q, last_d;
  logic           we_q, we_d, cle_q, cle_d, ale_q, ale_d, sec_q, sec_d;
  logic [CSW-1:0] cs_q, cs_d;
  logic [31:0]    wdata_q, wdata_d, rdata_q, rdata_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lane_d  = lane_q;
    last_d  = last_q;
    we_d    = we_q;
    cle_d   = cle_q;
    ale_d   = ale_q;
    sec_d   = sec_q;
    cs_d    = cs_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: if (start) begin
        we_d    = start_we;
        cle_d   = start_cle;
        ale_d   = start_ale;
        sec_d   = start_sec;
        cs_d    = start_cs;
        last_d  = start_last;
        wdata_d = start_wdata;
        lane_d  = 2'd0;
        if (start_flash) begin
          state_d = ST_SETUP;
          cnt_d   = SU_LD;
          rdata_d = '0;
        end else begin
          state_d = ST_DONE;
          rdata_d = start_rval;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_STROBE;
          cnt_d   = ST_LD;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          state_d = ST_HOLD;
          cnt_d   = HO_LD;
          if (!we_q) rdata_d[{lane_q, 3'b000} +: 8] = dq_in;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          if (lane_q == last_q) state_d = ST_DONE;
          else begin
            state_d = ST_SETUP;
            cnt_d   = SU_LD;
            lane_d  = lane_q + 2'd1;
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lane_q  <= '0;
      last_q  <= '0;
      we_q    <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      sec_q   <= 1'b0;
      cs_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lane_q  <= lane_d;
      last_q  <= last_d;
      we_q    <= we_d;
      cle_q   <= cle_d;
      ale_q   <= ale_d;
      sec_q   <= sec_d;
      cs_q    <= cs_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign ack     = (state_q == ST_DONE);
  assign rdata   = rdata_q;
  assign cyc_on  = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign cur_sec = sec_q;
  assign cur_cs  = cs_q;
  assign cle     = cyc_on && cle_q;
  assign ale     = cyc_on && ale_q;
  assign we_n    = !((state_q == ST_STROBE) && we_q);
  assign re_n    = !((state_q == ST_STROBE) && !we_q);
  assign dq_oe   = cyc_on && we_q;
  assign dq_out  = wdata_q[{lane_q, 3'b000} +: 8];

endmodule

// File: rtl/nand_cycle_bridge.sv
module nand_cycle_bridge
  import nand_bridge_pkg::*;
#(
  parameter int         AW        = 16,
  parameter int         NCS       = 4,
  parameter int         CSW       = (NCS > 1) ? $clog2(NCS) : 1,
  parameter int         SEC_BIT   = 12,
  parameter int         SETUP_CYC = 1,
  parameter int         STRB_CYC  = 2,
  parameter int         HOLD_CYC  = 1,
  parameter logic [7:0] REV_MAJOR = 8'd3,
  parameter logic [7:0] REV_MINOR = 8'd1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [1:0]     bus_size,
  input  logic [CSW-1:0] bus_cs,
  input  logic [31:0]    bus_wdata,
  output logic           bus_busy,
  output logic           bus_ack,
  output logic [31:0]    bus_rdata,
  output logic [NCS-1:0] nand_ce_n,
  output logic           nand_ce2_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [7:0]     nand_dq_out,
  output logic           nand_dq_oe,
  input  logic [7:0]     nand_dq_in,
  input  logic           nand_wait
);

  localparam int REG_BIT = AW - 1;

  logic           rst_m_q, rst_s_q;
  logic           accept, is_reg, cs_on;
  logic [NCS-1:0] mode_en;
  logic [31:0]    reg_val;
  logic           cyc_on, cur_sec;
  logic [CSW-1:0] cur_cs;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign is_reg = bus_addr[REG_BIT];
  assign accept = bus_req && !bus_busy;
  assign cs_on  = mode_en[bus_cs];

  nand_bridge_regs #(
    .NCS(NCS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .wr_ctrl (accept && is_reg && bus_we && (bus_addr[3:2] == 2'd0)),
    .wr_val  (bus_wdata[NCS-1:0]),
    .rd_sel  (bus_addr[3:2]),
    .wait_in (nand_wait),
    .mode_en (mode_en),
    .rd_val  (reg_val)
  );

  nand_bridge_seq #(
    .CSW(CSW), .SETUP_CYC(SETUP_CYC), .STRB_CYC(STRB_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .start       (accept),
    .start_flash (!is_reg && cs_on),
    .start_we    (bus_we),
    .start_cle   (bus_we && bus_addr[4]),
    .start_ale   (bus_we && !bus_addr[4] && bus_addr[3]),
    .start_sec   (bus_addr[SEC_BIT]),
    .start_cs    (bus_cs),
    .start_last  (last_lane(bus_size)),
    .start_wdata (bus_wdata),
    .start_rval  ((is_reg && !bus_we) ? reg_val : 32'd0),
    .dq_in       (nand_dq_in),
    .busy        (bus_busy),
    .ack         (bus_ack),
    .rdata       (bus_rdata),
    .cyc_on      (cyc_on),
    .cur_sec     (cur_sec),
    .cur_cs      (cur_cs),
    .cle         (nand_cle),
    .ale         (nand_ale),
    .we_n        (nand_we_n),
    .re_n        (nand_re_n),
    .dq_out      (nand_dq_out),
    .dq_oe       (nand_dq_oe)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_ce
    assign nand_ce_n[g] = !(cyc_on && !cur_sec && (cur_cs == CSW'(g)));
  end

  assign nand_ce2_n = !(cyc_on && cur_sec);

endmodule

// File: rtl/nand_bridge_checker.sv
module nand_bridge_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_busy,
  input logic           bus_ack,
  input logic [NCS-1:0] nand_ce_n,
  input logic           nand_ce2_n,
  input logic           nand_cle,
  input logic           nand_ale,
  input logic           nand_we_n,
  input logic           nand_re_n,
  input logic [7:0]     nand_dq_out
);

  // R1: command and address latches never high together
  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R5: write data held while the write strobe stays low
  a_r5_dq_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  // R5: never both strobes at once
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R8: at most one chip-enable asserted
  a_r8_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~nand_ce_n, ~nand_ce2_n}));

  // R11: busy only rises after a request
  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(bus_req));

  // R11: acknowledge drops busy on the next edge
  a_r11_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_busy);

  // R11: no flash activity when idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (nand_we_n && nand_re_n && nand_ce2_n && (&nand_ce_n)));

endmodule

bind nand_cycle_bridge nand_bridge_checker #(.NCS(NCS)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_busy    (bus_busy),
  .bus_ack     (bus_ack),
  .nand_ce_n   (nand_ce_n),
  .nand_ce2_n  (nand_ce2_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_dq_out (nand_dq_out)
);

// File: tb/test_nand_cycle_bridge.sv
module test_nand_cycle_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0, bus_cs = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_busy, bus_ack;
  logic [31:0] bus_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_ce2_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_wait = 1'b0;

  always #4 clk = ~clk;

  nand_cycle_bridge i_nand_cycle_bridge (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_cs(bus_cs),
    .bus_wdata(bus_wdata), .bus_busy(bus_busy), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_ce2_n(nand_ce2_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_wait(nand_wait)
  );

  typedef struct packed {
    logic       rd;
    logic       cle;
    logic       ale;
    logic [7:0] dq;
    logic [3:0] ce_n;
    logic       ce2_n;
  } lane_t;

  lane_t exp_q[$];
  int checks = 0, fails = 0, strobes = 0, rd_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_lane(input bit rd, input bit cle, input bit ale, input logic [7:0] dq,
                           input int cs, input bit sec);
    lane_t it;
    it.rd = rd; it.cle = cle; it.ale = ale; it.dq = dq;
    it.ce_n  = sec ? 4'hF : ~(4'b0001 << cs);
    it.ce2_n = !sec;
    exp_q.push_back(it);
  endtask

  task automatic bus_op(input bit we, input logic [15:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [1:0] cs, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = sz; bus_wdata = wd; bus_cs = cs;
    @(negedge clk);
    bus_req = 1'b0;
    while (!bus_ack) @(negedge clk);
    rd = bus_rdata;
  endtask

  // monitor: compare each strobe against the scoreboard, measure strobe width
  logic prev_we = 1'b1, prev_re = 1'b1;
  int   low_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) begin
        lane_t it;
        strobes++;
        if (!nand_re_n) begin
          nand_dq_in <= 8'h5A ^ 8'(rd_cnt);
          rd_cnt++;
        end
        if (exp_q.size() == 0) chk(0, "R11 unexpected strobe", 0, 0);
        else begin
          it = exp_q.pop_front();
          chk(!nand_re_n == it.rd, "R3 strobe kind", !nand_re_n, it.rd);
          chk(nand_cle == it.cle, "R1 cle", nand_cle, it.cle);
          chk(nand_ale == it.ale, "R2 ale", nand_ale, it.ale);
          chk(nand_ce_n == it.ce_n && nand_ce2_n == it.ce2_n, "R8 chip enables",
              {nand_ce2_n, nand_ce_n}, {it.ce2_n, it.ce_n});
          if (!it.rd) chk(nand_dq_out == it.dq && nand_dq_oe, "R4 lane data", nand_dq_out, it.dq);
        end
      end
      if (!nand_we_n || !nand_re_n) low_len++;
      else if (low_len != 0) begin
        chk(low_len == 2, "R5 strobe width", low_len, 2);
        low_len = 0;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!bus_busy && !bus_ack, "R11 reset idle", {bus_busy, bus_ack}, 0);
    chk(nand_we_n && nand_re_n, "R5 reset strobes", {nand_we_n, nand_re_n}, 2'b11);
    chk(nand_ce_n == 4'hF && nand_ce2_n, "R8 reset enables", {nand_ce2_n, nand_ce_n}, 5'h1F);
    chk(!nand_cle && !nand_ale, "R1 reset latches", {nand_cle, nand_ale}, 0);

    // R10 revision
    bus_op(0, 16'h8008, 2'd2, 0, 0, rd);
    chk(rd == 32'h0000_0301, "R10 revision", rd, 32'h301);

    // R9 status busy then ready
    bus_op(0, 16'h8004, 2'd2, 0, 0, rd);
    chk(rd == 32'd0, "R9 status busy", rd, 0);
    nand_wait = 1'b1;
    repeat (3) @(negedge clk);
    bus_op(0, 16'h8004, 2'd2, 0, 0, rd);
    chk(rd == 32'd1, "R9 status ready", rd, 1);

    // R7 disabled chip-select: no strobe
    s0 = strobes;
    bus_op(1, 16'h0000, 2'd2, 32'h1234_5678, 0, rd);
    repeat (4) @(negedge clk);
    chk(strobes == s0, "R7 disabled cs store", strobes, s0);

    // R7 enable cs0 and cs2, read back
    bus_op(1, 16'h8000, 2'd2, 32'h0000_0005, 0, rd);
    bus_op(0, 16'h8000, 2'd2, 0, 0, rd);
    chk(rd == 32'h5, "R7 control readback", rd, 5);

    // R1 command byte
    push_lane(0, 1, 0, 8'hFF, 0, 0);
    bus_op(1, 16'h0010, 2'd0, 32'hAABB_CCFF, 0, rd);

    // R2 + R4 address word, low address bits set, cs2
    push_lane(0, 0, 1, 8'h11, 2, 0);
    push_lane(0, 0, 1, 8'h22, 2, 0);
    push_lane(0, 0, 1, 8'h33, 2, 0);
    push_lane(0, 0, 1, 8'h44, 2, 0);
    bus_op(1, 16'h000B, 2'd2, 32'h4433_2211, 2, rd);

    // R1 priority when both bits set
    push_lane(0, 1, 0, 8'h90, 0, 0);
    bus_op(1, 16'h0018, 2'd0, 32'h0000_0090, 0, rd);

    // R3 + R4 data halfword
    push_lane(0, 0, 0, 8'hEF, 0, 0);
    push_lane(0, 0, 0, 8'hBE, 0, 0);
    bus_op(1, 16'h0002, 2'd1, 32'hFFFF_BEEF, 0, rd);

    // R6 word read, bytes 5A^n in lane order
    for (int k = 0; k < 4; k++) push_lane(1, 0, 0, 8'h00, 0, 0);
    bus_op(0, 16'h0000, 2'd2, 0, 0, rd);
    chk(rd == 32'h5958_5B5A, "R6 word read", rd, 32'h5958_5B5A);

    // R6 halfword read, upper bytes zero
    for (int k = 0; k < 2; k++) push_lane(1, 0, 0, 8'h00, 2, 0);
    bus_op(0, 16'h0013, 2'd1, 0, 2, rd);
    chk(rd == 32'h0000_5F5E, "R6 half read", rd, 32'h0000_5F5E);

    // R8 secondary chip-enable
    push_lane(0, 0, 0, 8'h77, 0, 1);
    bus_op(1, 16'h1000, 2'd0, 32'h0000_0077, 0, rd);

    // R7 disabled cs1 load
    s0 = strobes;
    bus_op(0, 16'h0000, 2'd2, 0, 1, rd);
    chk(rd == 32'd0, "R7 disabled cs load", rd, 0);
    chk(strobes == s0, "R7 disabled cs no strobe", strobes, s0);

    // R11 request during busy is dropped
    s0 = strobes;
    for (int k = 0; k < 4; k++) push_lane(0, 0, 0, 8'(8'hC0 + k), 0, 0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 16'h0000; bus_size = 2'd2;
    bus_wdata = 32'hC3C2_C1C0; bus_cs = 0;
    @(negedge clk);
    bus_req = 0;
    chk(bus_busy, "R11 busy after accept", bus_busy, 1);
    repeat (3) @(negedge clk);
    bus_req = 1; bus_addr = 16'h0010; bus_size = 2'd0; bus_wdata = 32'h0000_0066;
    @(negedge clk);
    bus_req = 0;
    while (!bus_ack) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(strobes - s0 == 4, "R11 dropped request", strobes - s0, 4);
    chk(!bus_busy, "R11 idle after ack", bus_busy, 0);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule